// File: doc/BRIEF.md
# H-Bridge Switch Control Logic

This block converts a direction input, a PWM input and a disable input into four registered gate-enable signals for a two-leg H-bridge. Leg 1 has switches `hs1_on`/`ls1_on` and leg 2 has `hs2_on`/`ls2_on`. The same block also provides four more functions:

- **Chopper current limit.** It works from already-synchronised high-side overcurrent flags. When a high side has been over its limit longer than a blanking window, the diagonal low side of the other leg is switched off. This lets the load current freewheel.
- **Spacing of chopper changes.** Successive chopper changes are separated by a minimum number of cycles.
- **Register override mode.** Stored register bits can take the place of the three pins.
- **Master shutdown.** An external fault manager can request that every switch is turned off.

All time constants are counted in system clock cycles:

- `FILT_CYC`: glitch filter on the disable pin.
- `BLANK_CYC`: blanking window.
- `TRANS_CYC`: minimum spacing between chopper changes.

The pins are registered once on entry. The gate outputs are registered once more before they leave the block. A PWM or direction change on the pins therefore reaches the gates two clock edges later.

Top module: `hbridge_ctrl`

## Requirements
- R1: With the bridge enabled in pin mode, the gates `{hs1_on,ls1_on,hs2_on,ls2_on}` follow the pins as follows:
  - `pwm_pin`=1, `dir_pin`=1 gives 1001.
  - `pwm_pin`=1, `dir_pin`=0 gives 0110.
  - `pwm_pin`=0, `dir_pin`=1 gives 1000.
  - `pwm_pin`=0, `dir_pin`=0 gives 0010.
- R2: A `dis_pin` high level that lasts `FILT_CYC` or more samples turns all four gates off. A high pulse shorter than `FILT_CYC` samples leaves the gates unchanged.
- R3: While `shutdown` is high, all four gates are off from the next clock edge onwards.
- R4: If `oc_hs1` stays high for more than `BLANK_CYC` cycles, `ls2_on` drops two edges after the set cycle. `hs1_on` stays on and `climit_act` goes high. An `oc_hs1` pulse of `BLANK_CYC` cycles or less changes nothing.
- R5: `oc_hs2` acts the same way on `ls1_on`, with `hs2_on` kept on.
- R6: Once the overcurrent flag falls, the forced low side is restored and `climit_act` clears. This happens only after `TRANS_CYC`+1 edges have passed since the previous chopper change. Chopper changes are never spaced closer than that.
- R7: A write with `cfg_wr`=1 and `cfg_sin`=1 enters override mode (`sw_mode_act`=1) only if `dis_pin`, `pwm_pin` and `dir_pin` are all low. Otherwise the write is ignored and the gates keep following the pins.
- R8: In override mode, three register bits replace the pins:
  - `sw_en`=1 enables the bridge in place of `dis_pin`=0.
  - `sw_dir` replaces `dir_pin`.
  - `sw_pwm` replaces `pwm_pin`.
  - The R1 mapping still applies.
- R9: In override mode, any change on `dis_pin`, `pwm_pin` or `dir_pin` clears `sw_mode_act` and returns control to the pins. A write with `cfg_sin`=0 also clears it.
- R10: `hs1_on` and `ls1_on` are never high together, and `hs2_on` and `ls2_on` are never high together.
- R11: During and directly after reset, all gates, `climit_act` and `sw_mode_act` are 0.
- R12: Disabling the bridge or asserting `shutdown` clears any chopper override. On re-enable, both low sides follow the truth table at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_pin | input | 1 | Bridge disable pin, high = off |
| pwm_pin | input | 1 | PWM pin |
| dir_pin | input | 1 | Direction pin |
| cfg_wr | input | 1 | One-cycle strobe: control register written |
| cfg_sin | input | 1 | Override-mode request bit carried by the write |
| sw_en | input | 1 | Register enable used in override mode |
| sw_dir | input | 1 | Register direction used in override mode |
| sw_pwm | input | 1 | Register PWM used in override mode |
| oc_hs1 | input | 1 | Synchronised overcurrent flag of high side 1 |
| oc_hs2 | input | 1 | Synchronised overcurrent flag of high side 2 |
| shutdown | input | 1 | Master shutdown request from the fault manager |
| hs1_on | output | 1 | High-side gate enable, leg 1 |
| ls1_on | output | 1 | Low-side gate enable, leg 1 |
| hs2_on | output | 1 | High-side gate enable, leg 2 |
| ls2_on | output | 1 | Low-side gate enable, leg 2 |
| climit_act | output | 1 | Chopper override in force on either side |
| sw_mode_act | output | 1 | Register override mode active |

## Verification
Two of the block's functions can act in the same cycle:

- **Chopper override and shutdown.** The bench holds `oc_hs1` until `ls2_on` has dropped, then raises `shutdown` while the override is still in force. It judges that the gates are off at the next edge. After `shutdown` falls, the override must be gone: `ls2_on` is expected back within two edges, well inside the transition spacing that would otherwise hold it off.
- **Override mode and a pin change.** The bench moves `dir_pin` while override mode is active. It expects `sw_mode_act` to clear and the gates to follow the pin truth table again. A later write with a pin high must leave the mode off.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic hs1;
    logic ls1;
    logic hs2;
    logic ls2;
  } hb_gates_t;

  localparam hb_gates_t HB_ALL_OFF = '0;
endpackage

// File: rtl/hb_in_stage.sv
module hb_in_stage #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_pin,
  input  logic pwm_pin,
  input  logic dir_pin,
  output logic dis_filt,
  output logic pwm_q,
  output logic dir_q,
  output logic pins_low,
  output logic pin_chg
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic          dis_q, dis_qq, pwm_qq, dir_qq;
  logic [FW-1:0] cnt, cnt_nx;
  logic          dis_filt_nx;

  // disable filter: follow dis_q only after it differs for FILT_CYC samples
  always_comb begin
    cnt_nx      = cnt;
    dis_filt_nx = dis_filt;
    if (dis_q == dis_filt) begin
      cnt_nx = '0;
    end else if (cnt == FW'(FILT_CYC - 1)) begin
      dis_filt_nx = dis_q;
      cnt_nx      = '0;
    end else begin
      cnt_nx = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q    <= 1'b1;
      dis_qq   <= 1'b1;
      pwm_q    <= 1'b0;
      pwm_qq   <= 1'b0;
      dir_q    <= 1'b0;
      dir_qq   <= 1'b0;
      cnt      <= '0;
      dis_filt <= 1'b1;
    end else begin
      dis_q    <= dis_pin;
      dis_qq   <= dis_q;
      pwm_q    <= pwm_pin;
      pwm_qq   <= pwm_q;
      dir_q    <= dir_pin;
      dir_qq   <= dir_q;
      cnt      <= cnt_nx;
      dis_filt <= dis_filt_nx;
    end
  end

  assign pins_low = !dis_q && !pwm_q && !dir_q;
  assign pin_chg  = (dis_q ^ dis_qq) | (pwm_q ^ pwm_qq) | (dir_q ^ dir_qq);
endmodule

// File: rtl/hb_mode_sel.sv
module hb_mode_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_filt,
  input  logic pwm_q,
  input  logic dir_q,
  input  logic pins_low,
  input  logic pin_chg,
  input  logic cfg_wr,
  input  logic cfg_sin,
  input  logic sw_en,
  input  logic sw_dir,
  input  logic sw_pwm,
  output logic sw_act,
  output logic eff_dis,
  output logic eff_pwm,
  output logic eff_dir
);
  logic sw_act_nx;

  // a pin change wins over a register write in the same cycle
  always_comb begin
    sw_act_nx = sw_act;
    if (pin_chg) begin
      sw_act_nx = 1'b0;
    end else if (cfg_wr) begin
      sw_act_nx = cfg_sin && pins_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_act <= 1'b0;
    end else begin
      sw_act <= sw_act_nx;
    end
  end

  assign eff_dis = sw_act ? !sw_en : dis_filt;
  assign eff_pwm = sw_act ? sw_pwm : pwm_q;
  assign eff_dir = sw_act ? sw_dir : dir_q;
endmodule

// File: rtl/hb_chopper.sv
module hb_chopper #(
  parameter int BLANK_CYC = 8,
  parameter int TRANS_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] oc,
  output logic [1:0] cut
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int GW = $clog2(TRANS_CYC + 1);

  logic [1:0]    want_set, want_rel, cut_nx;
  logic [GW-1:0] gap, gap_nx;
  logic          gap_ok;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [BW-1:0] blank, blank_nx;

    always_comb begin
      if (clr || !oc[s]) begin
        blank_nx = '0;
      end else if (blank != BW'(BLANK_CYC)) begin
        blank_nx = blank + 1'b1;
      end else begin
        blank_nx = blank;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blank <= '0;
      end else begin
        blank <= blank_nx;
      end
    end

    assign want_set[s] = oc[s] && (blank == BW'(BLANK_CYC)) && !cut[s];
    assign want_rel[s] = cut[s] && !oc[s];
  end

  assign gap_ok = (gap == GW'(TRANS_CYC));

  // one spacing counter shared by both sides: any change restarts it
  always_comb begin
    cut_nx = cut;
    gap_nx = gap;
    if (clr) begin
      cut_nx = '0;
      gap_nx = GW'(TRANS_CYC);
    end else begin
      if (gap_ok) begin
        cut_nx = (cut | want_set) & ~want_rel;
      end
      if (cut_nx != cut) begin
        gap_nx = '0;
      end else if (!gap_ok) begin
        gap_nx = gap + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut <= '0;
      gap <= GW'(TRANS_CYC);
    end else begin
      cut <= cut_nx;
      gap <= gap_nx;
    end
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int FILT_CYC  = 3,
  parameter int BLANK_CYC = 8,
  parameter int TRANS_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_pin,
  input  logic pwm_pin,
  input  logic dir_pin,
  input  logic cfg_wr,
  input  logic cfg_sin,
  input  logic sw_en,
  input  logic sw_dir,
  input  logic sw_pwm,
  input  logic oc_hs1,
  input  logic oc_hs2,
  input  logic shutdown,
  output logic hs1_on,
  output logic ls1_on,
  output logic hs2_on,
  output logic ls2_on,
  output logic climit_act,
  output logic sw_mode_act
);
  import hb_pkg::*;

  logic      dis_filt, pwm_q, dir_q, pins_low, pin_chg;
  logic      eff_dis, eff_pwm, eff_dir, bridge_off;
  logic [1:0] cut;
  hb_gates_t gates_q, gates_nx;
  logic      climit_q;

  hb_in_stage #(.FILT_CYC(FILT_CYC)) i_in (
    .clk(clk), .rst_n(rst_n),
    .dis_pin(dis_pin), .pwm_pin(pwm_pin), .dir_pin(dir_pin),
    .dis_filt(dis_filt), .pwm_q(pwm_q), .dir_q(dir_q),
    .pins_low(pins_low), .pin_chg(pin_chg)
  );

  hb_mode_sel i_mode (
    .clk(clk), .rst_n(rst_n),
    .dis_filt(dis_filt), .pwm_q(pwm_q), .dir_q(dir_q),
    .pins_low(pins_low), .pin_chg(pin_chg),
    .cfg_wr(cfg_wr), .cfg_sin(cfg_sin),
    .sw_en(sw_en), .sw_dir(sw_dir), .sw_pwm(sw_pwm),
    .sw_act(sw_mode_act),
    .eff_dis(eff_dis), .eff_pwm(eff_pwm), .eff_dir(eff_dir)
  );

  assign bridge_off = eff_dis || shutdown;

  hb_chopper #(.BLANK_CYC(BLANK_CYC), .TRANS_CYC(TRANS_CYC)) i_chop (
    .clk(clk), .rst_n(rst_n),
    .clr(bridge_off),
    .oc({oc_hs2, oc_hs1}),
    .cut(cut)
  );

  // truth table; the chopper only ever removes a low side
  always_comb begin
    gates_nx = HB_ALL_OFF;
    if (!bridge_off) begin
      gates_nx.hs1 = eff_dir;
      gates_nx.hs2 = !eff_dir;
      gates_nx.ls2 = eff_pwm && eff_dir && !cut[0];
      gates_nx.ls1 = eff_pwm && !eff_dir && !cut[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q  <= HB_ALL_OFF;
      climit_q <= 1'b0;
    end else begin
      gates_q  <= gates_nx;
      climit_q <= |cut;
    end
  end

  assign hs1_on     = gates_q.hs1;
  assign ls1_on     = gates_q.ls1;
  assign hs2_on     = gates_q.hs2;
  assign ls2_on     = gates_q.ls2;
  assign climit_act = climit_q;
endmodule

// File: rtl/hb_checker.sv
module hb_checker (
  input logic clk,
  input logic rst_n,
  input logic dis_pin,
  input logic pwm_pin,
  input logic dir_pin,
  input logic shutdown,
  input logic hs1_on,
  input logic ls1_on,
  input logic hs2_on,
  input logic ls2_on,
  input logic sw_mode_act
);
  // R10: leg 1 shoot-through
  a_r10_leg1_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1_on && ls1_on));

  // R10: leg 2 shoot-through
  a_r10_leg2_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs2_on && ls2_on));

  // R3: shutdown turns everything off at the next edge
  a_r3_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !(hs1_on || ls1_on || hs2_on || ls2_on));

  // R9: a pin change seen at the input stage ends override mode
  a_r9_pin_change_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dis_pin) != $past(dis_pin, 2)) || ($past(pwm_pin) != $past(pwm_pin, 2)) ||
     ($past(dir_pin) != $past(dir_pin, 2))) |=> !sw_mode_act);

  // R7: override mode only starts from all-low pins
  a_r7_entry_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_mode_act) |-> (!$past(dis_pin, 2) && !$past(pwm_pin, 2) && !$past(dir_pin, 2)));
endmodule

bind hbridge_ctrl hb_checker i_hb_checker (
  .clk(clk), .rst_n(rst_n),
  .dis_pin(dis_pin), .pwm_pin(pwm_pin), .dir_pin(dir_pin),
  .shutdown(shutdown),
  .hs1_on(hs1_on), .ls1_on(ls1_on), .hs2_on(hs2_on), .ls2_on(ls2_on),
  .sw_mode_act(sw_mode_act)
);

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;
  localparam int FILT  = 3;
  localparam int BLANK = 8;
  localparam int TRANS = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic dis_pin, pwm_pin, dir_pin, cfg_wr, cfg_sin, sw_en, sw_dir, sw_pwm;
  logic oc_hs1, oc_hs2, shutdown;
  logic hs1_on, ls1_on, hs2_on, ls2_on, climit_act, sw_mode_act;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  hbridge_ctrl #(.FILT_CYC(FILT), .BLANK_CYC(BLANK), .TRANS_CYC(TRANS)) i_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n),
    .dis_pin(dis_pin), .pwm_pin(pwm_pin), .dir_pin(dir_pin),
    .cfg_wr(cfg_wr), .cfg_sin(cfg_sin),
    .sw_en(sw_en), .sw_dir(sw_dir), .sw_pwm(sw_pwm),
    .oc_hs1(oc_hs1), .oc_hs2(oc_hs2), .shutdown(shutdown),
    .hs1_on(hs1_on), .ls1_on(ls1_on), .hs2_on(hs2_on), .ls2_on(ls2_on),
    .climit_act(climit_act), .sw_mode_act(sw_mode_act)
  );

  // {dis, pwm, dir, expected hs1 ls1 hs2 ls2}
  localparam logic [6:0] VEC [6] = '{
    7'b0_11_1001, 7'b0_10_0110, 7'b0_01_1000,
    7'b0_00_0010, 7'b1_11_0000, 7'b1_00_0000
  };

  function automatic logic [3:0] gates();
    return {hs1_on, ls1_on, hs2_on, ls2_on};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_pins(input logic d, input logic p, input logic r);
    dis_pin = d; pwm_pin = p; dir_pin = r;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen_off;
    rst_n = 1'b0;
    set_pins(1'b0, 1'b0, 1'b0);
    cfg_wr = 0; cfg_sin = 0; sw_en = 0; sw_dir = 0; sw_pwm = 0;
    oc_hs1 = 0; oc_hs2 = 0; shutdown = 0;
    tick(3);
    // R11: reset state
    chk("R11 in reset", {2'b0, gates(), climit_act, sw_mode_act}, 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R11 after reset", {2'b0, gates(), climit_act, sw_mode_act}, 8'h00);

    // R1 / R2: truth table walk
    for (int i = 0; i < 6; i++) begin
      set_pins(VEC[i][6], VEC[i][5], VEC[i][4]);
      tick(10);
      chk(VEC[i][6] ? "R2 disable" : "R1 truth table", {4'b0, gates()}, {4'b0, VEC[i][3:0]});
    end

    // R2: short disable pulse ignored
    set_pins(1'b0, 1'b1, 1'b1);
    tick(10);
    dis_pin = 1'b1;
    tick(FILT - 1);
    dis_pin = 1'b0;
    seen_off = 0;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (gates() != 4'b1001) seen_off++;
    end
    chk("R2 short pulse ignored", 8'(seen_off), 8'd0);
    // R2: pulse of FILT samples takes effect
    dis_pin = 1'b1;
    tick(FILT);
    dis_pin = 1'b0;
    seen_off = 0;
    for (int k = 0; k < 10; k++) begin
      tick(1);
      if (gates() == 4'b0000) seen_off++;
    end
    chk("R2 full pulse disables", 8'(seen_off > 0), 8'd1);
    tick(10);

    // R4: oc pulse of BLANK cycles does nothing
    oc_hs1 = 1'b1;
    tick(BLANK);
    oc_hs1 = 1'b0;
    tick(4);
    chk("R4 short overcurrent ignored", {3'b0, gates(), climit_act}, {3'b0, 4'b1001, 1'b0});
    tick(5);

    // R4: sustained overcurrent drops ls2 exactly after blanking
    oc_hs1 = 1'b1;
    tick(BLANK + 1);
    chk("R4 ls2 still on at blank edge", {7'b0, ls2_on}, 8'd1);
    tick(1);
    chk("R4 chopper engaged", {3'b0, gates(), climit_act}, {3'b0, 4'b1000, 1'b1});
    // R6: release waits for the transition spacing
    oc_hs1 = 1'b0;
    tick(TRANS);
    chk("R6 release held by spacing", {6'b0, ls2_on, climit_act}, 8'b01);
    tick(1);
    chk("R6 release after spacing", {6'b0, ls2_on, climit_act}, 8'b10);
    tick(2 * TRANS);

    // R5: side 2
    set_pins(1'b0, 1'b1, 1'b0);
    tick(10);
    oc_hs2 = 1'b1;
    tick(BLANK + 2);
    chk("R5 chopper side 2", {3'b0, gates(), climit_act}, {3'b0, 4'b0010, 1'b1});
    oc_hs2 = 1'b0;
    tick(2 * TRANS);
    chk("R5 side 2 restored", {3'b0, gates(), climit_act}, {3'b0, 4'b0110, 1'b0});

    // R3 + R12: shutdown while chopper active
    set_pins(1'b0, 1'b1, 1'b1);
    tick(2 * TRANS);
    oc_hs1 = 1'b1;
    tick(BLANK + 2);
    chk("R4 engaged before shutdown", {7'b0, climit_act}, 8'd1);
    shutdown = 1'b1;
    oc_hs1 = 1'b0;
    tick(1);
    chk("R3 shutdown all off", {4'b0, gates()}, 8'h00);
    tick(3);
    shutdown = 1'b0;
    tick(2);
    chk("R12 chopper cleared by shutdown", {3'b0, gates(), climit_act}, {3'b0, 4'b1001, 1'b0});

    // R7 / R8: override mode
    set_pins(1'b0, 1'b0, 1'b0);
    tick(10);
    chk("R1 pins low", {4'b0, gates()}, 8'b0010);
    sw_en = 1; sw_dir = 1; sw_pwm = 1;
    cfg_sin = 1; cfg_wr = 1;
    tick(1);
    cfg_wr = 0;
    tick(3);
    chk("R8 override drives", {3'b0, gates(), sw_mode_act}, {3'b0, 4'b1001, 1'b1});
    sw_dir = 0;
    tick(2);
    chk("R8 override direction", {4'b0, gates()}, 8'b0110);
    sw_en = 0;
    tick(2);
    chk("R8 override disable", {4'b0, gates()}, 8'b0000);
    sw_en = 1;
    // R9: pin change exits
    dir_pin = 1'b1;
    tick(4);
    chk("R9 pin change exits", {3'b0, gates(), sw_mode_act}, {3'b0, 4'b1000, 1'b0});
    // R7: write with a pin high is ignored
    cfg_wr = 1;
    tick(1);
    cfg_wr = 0;
    tick(4);
    chk("R7 write ignored", {3'b0, gates(), sw_mode_act}, {3'b0, 4'b1000, 1'b0});
    // R9: write of cfg_sin=0 leaves the mode
    dir_pin = 1'b0;
    tick(6);
    cfg_wr = 1;
    tick(1);
    cfg_wr = 0;
    tick(3);
    chk("R7 entry from low pins", {7'b0, sw_mode_act}, 8'd1);
    cfg_sin = 0; cfg_wr = 1;
    tick(1);
    cfg_wr = 0;
    tick(3);
    chk("R9 cleared by write", {3'b0, gates(), sw_mode_act}, {3'b0, 4'b0010, 1'b0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule